// File: doc/BRIEF.md
# Multi-mode PWM channel generator

This block drives up to four pulse-width-modulated channels from one shared timer counter. A programmable prescaler slows the counter tick below the system clock. The counter runs in one of three counting modes: upward, downward, or center-aligned (up then down). Each channel owns a compare value and a true output. A parameter chooses which channels also have a complementary output.

Software issues one request at a time: a channel number, which output of that channel (true or complementary), a polarity, and the desired period and pulse in counter ticks. The block converts these counts into reload and compare values to suit the counting mode. Reload and compare values pass through preload registers. The first enable of an output forces an update at once and restarts the counter. Requests made while that output is already running are held until the counter's next natural update. A request that cannot be honoured raises a one-cycle error strobe and leaves every setting as it was.

Top module: `pwm_gen`

## Requirements
- R1: The counter advances once every prescale+1 clock cycles. Every output length is therefore a tick count multiplied by prescale+1.
- R2: In up mode (cntMode=0) the counter runs 0..reload with reload = period-1 and compare = pulse. The active phase lasts `pulse` ticks of every `period` ticks, and the output is active while count < compare.
- R3: In down mode (cntMode=1) the counter runs reload..0. Both counts are loaded minus one, and the output is active while count <= compare. This gives `pulse` active ticks of every `period` ticks for pulse >= 1.
- R4: In center-aligned mode (cntMode=2 or 3) period and pulse are each halved before loading. One cycle is 2*floor(period/2) ticks with 2*floor(pulse/2) active ticks, and the active ticks are contiguous around the counter's zero.
- R5: A period larger than 2^CNT_W is rejected. A period of exactly 2^CNT_W is accepted.
- R6: A period of zero turns off only the selected output (true or complementary). It leaves that output's polarity, the other output and every other channel unchanged. An output that is off drives 0, and all outputs are 0 after reset.
- R7: A polarity bit of 0 makes an output active-high and a bit of 1 makes it active-low. The complementary output is active while the true reference is inactive.
- R8: Enabling one output of a channel keeps the enable and polarity of that channel's other output.
- R9: When a request enables an output that was off, the new reload and compare values apply at once and the counter restarts. Any later request for a running output updates its preload only, so the waveform changes at the next wrap.
- R10: A request for channel 0, for a channel above NUM_CH (reqChannel is 1-based), or for a complementary output on a channel without one pulses reqError in the following cycle and changes no state.
- R11: All channels share one counter and reload but keep separate compare values, so channels with different pulses run at the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntMode | input | 2 | Counting mode: 0 up, 1 down, 2/3 center-aligned |
| prescale | input | PSC_W | Tick divider minus one |
| reqValid | input | 1 | Request strobe, one cycle |
| reqChannel | input | $clog2(NUM_CH+1) | Target channel, 1-based |
| reqComp | input | 1 | 1 selects the complementary output |
| reqInvert | input | 1 | 1 selects active-low polarity |
| reqPeriod | input | REQ_W | Requested period in ticks, 0 turns the output off |
| reqPulse | input | REQ_W | Requested active length in ticks |
| reqError | output | 1 | One-cycle strobe for a rejected request |
| pwmTrue | output | NUM_CH | True outputs |
| pwmComp | output | NUM_CH | Complementary outputs |

## Verification
Active and inactive run lengths are measured on each output after it settles. The requests are chosen so that each counting mode's count adjustment gives a distinct result: an up-mode pair of 10/3, a down-mode pulse of one, and an odd center-aligned period that exposes the halving. Inverted and complementary runs are told apart from normal ones by their swapped lengths. A prescale of 2 tells tick counting apart from clock counting. A pulse change issued mid-period shows whether the preload is deferred or applied at once. Rejected requests are followed by checks that the outputs keep their earlier waveforms.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  typedef enum logic [1:0] {
    CM_UP      = 2'd0,
    CM_DOWN    = 2'd1,
    CM_CENTER  = 2'd2,
    CM_CENTER2 = 2'd3
  } cnt_mode_e;

  // strobes from request control to the counter datapath
  typedef struct packed {
    logic wrPre;     // write reload/compare preload
    logic forceUpd;  // copy preload to active now and restart counter
  } upd_strobe_t;
endpackage

// File: rtl/pwm_gen_ctrl.sv
module pwm_gen_ctrl
  import pwm_gen_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int REQ_W  = 32,
  parameter int CSEL_W = 3,
  parameter int CH_W   = 2,
  parameter logic [NUM_CH-1:0] HAS_COMP = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cntMode,
  input  logic              reqValid,
  input  logic [CSEL_W-1:0] reqChannel,
  input  logic              reqComp,
  input  logic              reqInvert,
  input  logic [REQ_W-1:0]  reqPeriod,
  input  logic [REQ_W-1:0]  reqPulse,
  output upd_strobe_t       stb,
  output logic [CH_W-1:0]   chIdx,
  output logic [CNT_W-1:0]  arrVal,
  output logic [CNT_W-1:0]  cmpVal,
  output logic [NUM_CH-1:0] trueEn,
  output logic [NUM_CH-1:0] compEn,
  output logic [NUM_CH-1:0] truePol,
  output logic [NUM_CH-1:0] compPol,
  output logic              reqError
);
  localparam logic [REQ_W:0]   PERIOD_LIM = (REQ_W+1)'(1) << CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX    = '1;

  logic chOk, hasComp, tooLong, badReq, goodReq, isOff, selEn;
  logic [REQ_W-1:0] arrW, cmpW;

  always_comb begin
    chOk    = (reqChannel != '0) && (reqChannel <= CSEL_W'(NUM_CH));
    chIdx   = chOk ? CH_W'(reqChannel - CSEL_W'(1)) : '0;
    hasComp = HAS_COMP[chIdx];
    tooLong = {1'b0, reqPeriod} > PERIOD_LIM;
    badReq  = !chOk || (reqComp && !hasComp) || tooLong;
    goodReq = reqValid && !badReq;
    isOff   = (reqPeriod == '0);
    selEn   = reqComp ? compEn[chIdx] : trueEn[chIdx];

    // per-mode count adjustment
    if (cntMode[1]) begin
      arrW = reqPeriod >> 1;
      cmpW = reqPulse >> 1;
    end else if (cntMode == CM_DOWN) begin
      arrW = reqPeriod - REQ_W'(1);
      cmpW = reqPulse - REQ_W'(1);
    end else begin
      arrW = reqPeriod - REQ_W'(1);
      cmpW = reqPulse;
    end
    arrVal = CNT_W'(arrW);
    cmpVal = (cmpW > REQ_W'(CNT_MAX)) ? CNT_MAX : CNT_W'(cmpW);

    stb.wrPre    = goodReq && !isOff;
    stb.forceUpd = goodReq && !isOff && !selEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trueEn   <= '0;
      compEn   <= '0;
      truePol  <= '0;
      compPol  <= '0;
      reqError <= 1'b0;
    end else begin
      reqError <= reqValid && badReq;
      if (goodReq) begin
        if (reqComp) begin
          compEn[chIdx] <= !isOff;
          if (!isOff) compPol[chIdx] <= reqInvert;
        end else begin
          trueEn[chIdx] <= !isOff;
          if (!isOff) truePol[chIdx] <= reqInvert;
        end
      end
    end
  end

  p_err_keeps_state_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqError |-> ($stable(trueEn) && $stable(compEn) && $stable(truePol) && $stable(compPol)));

  p_load_enables_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrPre && !reqComp) |=> trueEn[$past(chIdx)]);
endmodule

// File: rtl/pwm_gen_dp.sv
module pwm_gen_dp
  import pwm_gen_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cntMode,
  input  logic [PSC_W-1:0]  prescale,
  input  upd_strobe_t       stb,
  input  logic [CH_W-1:0]   chIdx,
  input  logic [CNT_W-1:0]  arrVal,
  input  logic [CNT_W-1:0]  cmpVal,
  input  logic [NUM_CH-1:0] trueEn,
  input  logic [NUM_CH-1:0] compEn,
  input  logic [NUM_CH-1:0] truePol,
  input  logic [NUM_CH-1:0] compPol,
  output logic [NUM_CH-1:0] pwmTrue,
  output logic [NUM_CH-1:0] pwmComp
);
  logic [PSC_W-1:0] pscCnt;
  logic [CNT_W-1:0] cnt, arrPre, arrAct;
  logic [CNT_W-1:0] ccrPre [NUM_CH];
  logic [CNT_W-1:0] ccrAct [NUM_CH];
  logic dirDown, tick, wrapEvt, isDown, isCenter;
  logic [NUM_CH-1:0] refRaw;

  always_comb begin
    isDown   = (cntMode == CM_DOWN);
    isCenter = cntMode[1];
    tick     = (pscCnt >= prescale);
    if (isCenter)    wrapEvt = tick && dirDown && (cnt <= CNT_W'(1));
    else if (isDown) wrapEvt = tick && (cnt == '0);
    else             wrapEvt = tick && (cnt >= arrAct);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pscCnt  <= '0;
      cnt     <= '0;
      dirDown <= 1'b0;
      arrPre  <= '0;
      arrAct  <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        ccrPre[i] <= '0;
        ccrAct[i] <= '0;
      end
    end else begin
      if (stb.wrPre) begin
        arrPre        <= arrVal;
        ccrPre[chIdx] <= cmpVal;
      end
      if (stb.forceUpd) begin
        arrAct <= arrVal;
        for (int i = 0; i < NUM_CH; i++)
          ccrAct[i] <= (CH_W'(i) == chIdx) ? cmpVal : ccrPre[i];
        cnt     <= isDown ? arrVal : '0;
        dirDown <= 1'b0;
        pscCnt  <= '0;
      end else begin
        pscCnt <= tick ? '0 : pscCnt + PSC_W'(1);
        if (wrapEvt) begin
          arrAct <= arrPre;
          for (int i = 0; i < NUM_CH; i++) ccrAct[i] <= ccrPre[i];
          cnt     <= isDown ? arrPre : '0;
          dirDown <= 1'b0;
        end else if (tick) begin
          if (isDown) cnt <= cnt - CNT_W'(1);
          else if (!isCenter) cnt <= cnt + CNT_W'(1);
          else if (dirDown) cnt <= cnt - CNT_W'(1);
          else if (cnt >= arrAct) begin
            dirDown <= 1'b1;
            cnt     <= (cnt == '0) ? '0 : cnt - CNT_W'(1);
          end else cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_comb begin
      if (isDown || (isCenter && (dirDown || cnt >= arrAct)))
        refRaw[g] = (cnt <= ccrAct[g]);
      else
        refRaw[g] = (cnt < ccrAct[g]);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pwmTrue[g] <= 1'b0;
        pwmComp[g] <= 1'b0;
      end else begin
        pwmTrue[g] <= trueEn[g] & (refRaw[g] ^ truePol[g]);
        pwmComp[g] <= compEn[g] & (~refRaw[g] ^ compPol[g]);
      end
    end

    p_off_low_r6: assert property (@(posedge clk) disable iff (!rstN)
      (!trueEn[g] |=> !pwmTrue[g]) and (!compEn[g] |=> !pwmComp[g]));

    p_comp_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
      (trueEn[g] && compEn[g] && !truePol[g] && !compPol[g]) |=> !(pwmTrue[g] && pwmComp[g]));
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN) cnt <= arrAct);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.forceUpd && !isDown) |=> (cnt == '0));
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int REQ_W  = 32,
  parameter int PSC_W  = 16,
  parameter logic [NUM_CH-1:0] HAS_COMP = 4'b0111,
  localparam int CSEL_W = $clog2(NUM_CH + 1),
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cntMode,
  input  logic [PSC_W-1:0]  prescale,
  input  logic              reqValid,
  input  logic [CSEL_W-1:0] reqChannel,
  input  logic              reqComp,
  input  logic              reqInvert,
  input  logic [REQ_W-1:0]  reqPeriod,
  input  logic [REQ_W-1:0]  reqPulse,
  output logic              reqError,
  output logic [NUM_CH-1:0] pwmTrue,
  output logic [NUM_CH-1:0] pwmComp
);
  upd_strobe_t       stb;
  logic [CH_W-1:0]   chIdx;
  logic [CNT_W-1:0]  arrVal, cmpVal;
  logic [NUM_CH-1:0] trueEn, compEn, truePol, compPol;

  pwm_gen_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .REQ_W(REQ_W), .CSEL_W(CSEL_W),
                 .CH_W(CH_W), .HAS_COMP(HAS_COMP)) ctrl_i (
    .clk, .rstN, .cntMode, .reqValid, .reqChannel, .reqComp, .reqInvert,
    .reqPeriod, .reqPulse, .stb, .chIdx, .arrVal, .cmpVal,
    .trueEn, .compEn, .truePol, .compPol, .reqError);

  pwm_gen_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PSC_W(PSC_W), .CH_W(CH_W)) dp_i (
    .clk, .rstN, .cntMode, .prescale, .stb, .chIdx, .arrVal, .cmpVal,
    .trueEn, .compEn, .truePol, .compPol, .pwmTrue, .pwmComp);
endmodule

// File: tb/pwm_gen_tb_top.sv
module pwm_gen_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic [1:0]  cntMode;
  logic [15:0] prescale;
  logic        reqValid, reqComp, reqInvert;
  logic [2:0]  reqChannel;
  logic [31:0] reqPeriod, reqPulse;
  logic        reqError;
  logic [3:0]  pwmTrue, pwmComp;

  int total = 0;
  int bad = 0;
  bit lastErr;
  bit finished = 0;

  typedef struct {int sig; int hi; int lo; string tag;} exp_t;
  exp_t expQ[$];

  pwm_gen dut_i (.clk, .rstN, .cntMode, .prescale, .reqValid, .reqChannel, .reqComp,
                 .reqInvert, .reqPeriod, .reqPulse, .reqError, .pwmTrue, .pwmComp);

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // signal ids: 0..3 true outputs, 4..7 complementary outputs
  function automatic logic getSig(int id);
    return (id < 4) ? pwmTrue[id] : pwmComp[id-4];
  endfunction

  task automatic waitRise(int id);
    logic prev, cur;
    cur = getSig(id);
    do begin
      @(negedge clk);
      prev = cur;
      cur  = getSig(id);
    end while (!(!prev && cur));
  endtask

  // monitor: measures the settled waveform and compares it with the queue head
  initial forever begin
    exp_t e;
    int hi, lo;
    wait (expQ.size() > 0);
    e = expQ[0];
    waitRise(e.sig);
    waitRise(e.sig);
    hi = 0;
    while (getSig(e.sig)) begin hi++; @(negedge clk); end
    lo = 0;
    while (!getSig(e.sig)) begin lo++; @(negedge clk); end
    check(hi == e.hi, e.tag, $sformatf("active length sig%0d", e.sig), hi, e.hi);
    check(lo == e.lo, e.tag, $sformatf("inactive length sig%0d", e.sig), lo, e.lo);
    void'(expQ.pop_front());
  end

  task automatic expectWave(int sig, int hi, int lo, string tag);
    exp_t e;
    e.sig = sig; e.hi = hi; e.lo = lo; e.tag = tag;
    expQ.push_back(e);
    wait (expQ.size() == 0);
  endtask

  task automatic doReset(logic [1:0] mode, int psc);
    @(negedge clk);
    rstN = 1'b0; cntMode = mode; prescale = 16'(psc);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(int ch, bit comp, bit inv, int unsigned per, int unsigned pul);
    @(negedge clk);
    reqValid = 1'b1; reqChannel = 3'(ch); reqComp = comp; reqInvert = inv;
    reqPeriod = per; reqPulse = pul;
    @(negedge clk);
    reqValid = 1'b0;
    lastErr = reqError;
  endtask

  task automatic quietWindow(int ch, string tag);
    int ones = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (pwmTrue[ch] || pwmComp[ch]) ones++;
    end
    check(ones == 0, tag, $sformatf("active samples ch%0d", ch + 1), ones, 0);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqChannel = '0; reqComp = 1'b0; reqInvert = 1'b0;
    reqPeriod = '0; reqPulse = '0; cntMode = 2'd0; prescale = '0;

    // reset state
    doReset(2'd0, 0);
    check(pwmTrue == 4'b0, "R6", "true outputs after reset", pwmTrue, 0);
    check(pwmComp == 4'b0, "R6", "comp outputs after reset", pwmComp, 0);
    check(reqError == 1'b0, "R10", "error after reset", reqError, 0);

    // up mode, two channels sharing the counter
    send(1, 0, 0, 10, 3);
    check(lastErr == 1'b0, "R2", "error on valid request", lastErr, 0);
    expectWave(0, 3, 7, "R2");
    send(2, 0, 0, 10, 6);
    expectWave(1, 6, 4, "R11");
    expectWave(0, 3, 7, "R11");

    // inverted polarity
    send(3, 0, 1, 10, 3);
    expectWave(2, 7, 3, "R7");

    // complementary output keeps the true output as it was
    send(1, 1, 0, 10, 3);
    expectWave(4, 7, 3, "R7");
    expectWave(0, 3, 7, "R8");

    // rejected requests
    send(4, 1, 0, 10, 3);
    check(lastErr == 1'b1, "R10", "error for missing complementary", lastErr, 1);
    quietWindow(3, "R10");
    send(0, 0, 0, 10, 3);
    check(lastErr == 1'b1, "R10", "error for channel 0", lastErr, 1);
    send(5, 0, 0, 10, 3);
    check(lastErr == 1'b1, "R10", "error for channel 5", lastErr, 1);
    expectWave(0, 3, 7, "R10");

    // zero period turns off only the true output of channel 1
    send(1, 0, 0, 0, 0);
    check(lastErr == 1'b0, "R6", "error on zero period", lastErr, 0);
    begin
      int ones = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (pwmTrue[0]) ones++;
      end
      check(ones == 0, "R6", "true ch1 active samples after off", ones, 0);
    end
    expectWave(4, 7, 3, "R6");

    // first enable is immediate, later change waits for the wrap
    doReset(2'd0, 0);
    send(1, 0, 0, 40, 10);
    @(negedge clk);
    check(pwmTrue[0] == 1'b1, "R9", "output right after first enable", pwmTrue[0], 1);
    repeat (18) @(negedge clk);
    send(1, 0, 0, 40, 30);
    repeat (5) @(negedge clk);
    check(pwmTrue[0] == 1'b0, "R9", "output before wrap after change", pwmTrue[0], 0);
    expectWave(0, 30, 10, "R9");

    // prescaler
    doReset(2'd0, 2);
    send(1, 0, 0, 8, 2);
    expectWave(0, 6, 18, "R1");

    // down mode
    doReset(2'd1, 0);
    send(1, 0, 0, 10, 4);
    expectWave(0, 4, 6, "R3");
    send(2, 0, 0, 10, 1);
    expectWave(1, 1, 9, "R3");

    // center-aligned mode, even and odd requests
    doReset(2'd2, 0);
    send(1, 0, 0, 12, 4);
    expectWave(0, 4, 8, "R4");
    send(2, 0, 0, 13, 7);
    expectWave(1, 6, 6, "R4");

    // period limit of a 16-bit counter
    doReset(2'd0, 0);
    send(1, 0, 0, 65537, 5);
    check(lastErr == 1'b1, "R5", "error for period 65537", lastErr, 1);
    @(negedge clk);
    check(pwmTrue[0] == 1'b0, "R5", "output after rejected period", pwmTrue[0], 0);
    send(1, 0, 0, 65536, 5);
    check(lastErr == 1'b0, "R5", "error for period 65536", lastErr, 0);
    @(negedge clk);
    check(pwmTrue[0] == 1'b1, "R5", "output after accepted period", pwmTrue[0], 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule